// File: doc/BRIEF.md
# Cold/Warm Reset Sequencer

This controller orders the reset releases for a small processor subsystem that has its own clock-control unit. A power-on reset or a cold request puts everything into reset, the clock-control unit included. When the source is removed, the clock unit comes out of reset first. The module resets stay asserted until that unit reports that its boot clock is running. They are then released one group at a time, lowest index first, at a fixed spacing.

A warm request leaves the clock unit running. It asserts every module reset and asks the clock unit to enter its boot mode through a level request/acknowledge handshake. The module groups are released only after the acknowledge arrives. A cold request that arrives while a warm sequence is in progress takes priority: the sequence restarts from the cold path. A busy output covers each sequence, from its start until the last group is released.

States:
- `ST_COLD_HOLD`: everything is held in reset. This is the asynchronous reset state.
- `ST_CLK_WAIT`: the clock unit is running, and the sequencer waits for boot-clock ready.
- `ST_WARM_DRAIN`: the sequencer waits for a stale acknowledge to fall.
- `ST_BOOT_REQ`: the boot-mode request is raised.
- `ST_RELEASE`: the groups are released one by one.
- `ST_IDLE`: all resets are released.

Transitions:
- `ST_COLD_HOLD` goes to `ST_CLK_WAIT` on the first edge after the reset source is removed.
- `ST_CLK_WAIT` goes to `ST_RELEASE` when ready is seen.
- `ST_IDLE` goes to `ST_BOOT_REQ` on a warm request. If the acknowledge is still high, it goes to `ST_WARM_DRAIN` instead.
- `ST_WARM_DRAIN` goes to `ST_BOOT_REQ` once the acknowledge is low.
- `ST_BOOT_REQ` goes to `ST_RELEASE` on the acknowledge.
- `ST_RELEASE` goes to `ST_IDLE` on the edge that releases the last group.
- Any state goes to `ST_COLD_HOLD` asynchronously on a power-on or cold reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `clku_rst_n` is low, every bit of `mod_rst_n` is low. On a cold sequence, `clku_rst_n` rises before any `mod_rst_n` bit rises.
- R2: After the reset source is removed, `clku_rst_n` rises within SYNC_STAGES+2 cycles. `mod_rst_n` stays all-zero for as long as `clku_clk_ready` stays low.
- R3: A warm sequence never drives `clku_rst_n` low.
- R4: An accepted warm request drives every `mod_rst_n` bit low (all bits are warm-affected) and raises `clku_boot_req`.
- R5: No module group is released while `clku_boot_req` is high, or before `clku_boot_ack` has been seen.
- R6: `clku_boot_req` is a level that is held until `clku_boot_ack` is sampled high. It is low in the following cycle. It is never raised while the acknowledge is still high from an earlier handshake.
- R7: `mod_rst_n` is active low, and bit k drives group k. Bits are released in ascending order, one every STEP (default 4) cycles. Bit k rises STEP*(k+1) clock edges after the edge that samples the acknowledge or ready.
- R8: `busy` is high from the start of any sequence and falls in the same cycle that the last group is released. While `busy` is low, all resets are released and no request is raised.
- R9: A cold request during a warm sequence asserts `clku_rst_n` and every module reset, and drops `clku_boot_req`. The sequence then restarts along the cold path.
- R10: A low `por_n` or a high `cold_req` asserts all reset outputs asynchronously, without waiting for a clock edge. The release of that source is synchronized through SYNC_STAGES flops.
- R11: A warm request that arrives while a sequence is in progress (not in `ST_IDLE`) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| cold_req | input | 1 | Cold-reset request, active high, asynchronous assertion |
| warm_req | input | 1 | Warm-reset request, active high, synchronized level |
| clku_boot_ack | input | 1 | Boot-mode acknowledge from the clock unit |
| clku_clk_ready | input | 1 | Clock unit reports that the boot clock is running |
| clku_rst_n | output | 1 | Reset to the clock unit, active low |
| mod_rst_n | output | NGRP | Module group resets, active low, bit k is group k |
| clku_boot_req | output | 1 | Boot-mode request to the clock unit (level) |
| busy | output | 1 | A reset sequence is in progress |

## Verification
A cold request can coincide with a warm handshake in flight. It can also arrive in the same cycle as a new warm request. The bench raises `cold_req` both while `clku_boot_req` is waiting for the acknowledge and in the very cycle that `warm_req` rises. The result is judged correct when, a moment later and before any clock edge, `clku_rst_n` and every module reset are low and the request has dropped. After that, the full cold-path release must follow, with the clock unit released first.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_COLD_HOLD  = 3'd0,
        ST_CLK_WAIT   = 3'd1,
        ST_WARM_DRAIN = 3'd2,
        ST_BOOT_REQ   = 3'd3,
        ST_RELEASE    = 3'd4,
        ST_IDLE       = 3'd5
    } rseq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
// Multi-flop synchronizer with asynchronous clear to RST_VAL.
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= {STAGES{RST_VAL}};
        else         sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rstseq_stepper.sv
// Counts release groups: one increment every STEP cycles while run is high.
module rstseq_stepper #(
    parameter int NGRP = 4,
    parameter int STEP = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    output logic [$clog2(NGRP+1)-1:0] rel_cnt,
    output logic                      last_tick
);
    localparam int CW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam int GW = $clog2(NGRP+1);

    logic [CW-1:0] cyc;
    logic          tick;

    assign tick      = run && (cyc == CW'(STEP-1));
    assign last_tick = tick && (rel_cnt == GW'(NGRP-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc     <= '0;
            rel_cnt <= '0;
        end else if (!run) begin
            cyc     <= '0;
            rel_cnt <= '0;
        end else if (tick) begin
            cyc     <= '0;
            rel_cnt <= rel_cnt + GW'(1);
        end else begin
            cyc <= cyc + CW'(1);
        end
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int NGRP        = 4,
    parameter int STEP        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            cold_req,
    input  logic            warm_req,
    input  logic            clku_boot_ack,
    input  logic            clku_clk_ready,
    output logic            clku_rst_n,
    output logic [NGRP-1:0] mod_rst_n,
    output logic            clku_boot_req,
    output logic            busy
);
    localparam int GW = $clog2(NGRP+1);

    logic          src_n;
    logic          rst_n;
    logic          warm_s;
    logic          run;
    logic          last_tick;
    logic [GW-1:0] rel_cnt;
    logic [NGRP-1:0] therm;
    rseq_state_e   state_q, state_d;

    // Reset source: asynchronous assertion, synchronous release
    assign src_n = por_n & ~cold_req;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk    (clk),
        .arst_n (src_n),
        .d      (1'b1),
        .q      (rst_n)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_warm_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .d      (warm_req),
        .q      (warm_s)
    );

    assign run = (state_q == ST_RELEASE);

    rstseq_stepper #(.NGRP(NGRP), .STEP(STEP)) u_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rel_cnt   (rel_cnt),
        .last_tick (last_tick)
    );

    // Thermometer of released groups, lowest index first
    for (genvar g = 0; g < NGRP; g++) begin : g_therm
        assign therm[g] = (rel_cnt > GW'(g));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLD_HOLD;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD_HOLD:  state_d = ST_CLK_WAIT;
            ST_CLK_WAIT:   if (clku_clk_ready) state_d = ST_RELEASE;
            ST_IDLE:       if (warm_s) state_d = clku_boot_ack ? ST_WARM_DRAIN : ST_BOOT_REQ;
            ST_WARM_DRAIN: if (!clku_boot_ack) state_d = ST_BOOT_REQ;
            ST_BOOT_REQ:   if (clku_boot_ack) state_d = ST_RELEASE;
            ST_RELEASE:    if (last_tick) state_d = ST_IDLE;
            default:       state_d = ST_COLD_HOLD;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        clku_rst_n    = 1'b1;
        mod_rst_n     = '0;
        clku_boot_req = 1'b0;
        busy          = 1'b1;
        unique case (state_q)
            ST_COLD_HOLD:  clku_rst_n = 1'b0;
            ST_CLK_WAIT:   ;
            ST_WARM_DRAIN: ;
            ST_BOOT_REQ:   clku_boot_req = 1'b1;
            ST_RELEASE:    mod_rst_n = therm;
            ST_IDLE: begin
                mod_rst_n = '1;
                busy      = 1'b0;
            end
            default:       clku_rst_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int NGRP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clku_rst_n,
    input logic [NGRP-1:0] mod_rst_n,
    input logic            clku_boot_req,
    input logic            clku_boot_ack,
    input logic            busy
);
    logic [NGRP-1:0] inc;
    assign inc = mod_rst_n + NGRP'(1);

    // R1: modules held while the clock unit is in reset
    a_r1_clku_first: assert property (@(posedge clk) disable iff (!rst_n)
        !clku_rst_n |-> (mod_rst_n == '0));

    // R3: clock-unit reset only falls through the reset path
    a_r3_no_clku_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(clku_rst_n));

    // R5: no release while boot request pending
    a_r5_hold_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        clku_boot_req |-> (mod_rst_n == '0));

    // R6: request dropped after acknowledge
    a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (clku_boot_req && clku_boot_ack) |=> !clku_boot_req);

    // R6: no new request while old acknowledge high
    a_r6_no_req_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clku_boot_req) |-> !$past(clku_boot_ack));

    // R7: released bits always form a low-side thermometer
    a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
        (inc & mod_rst_n) == '0);

    // R8: idle means everything released and nothing requested
    a_r8_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((&mod_rst_n) && clku_rst_n && !clku_boot_req));
endmodule

bind rstseq_ctrl rstseq_chk #(.NGRP(NGRP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clku_rst_n    (clku_rst_n),
    .mod_rst_n     (mod_rst_n),
    .clku_boot_req (clku_boot_req),
    .clku_boot_ack (clku_boot_ack),
    .busy          (busy)
);

// File: tb/tb_rstseq_ctrl.sv
`timescale 1ns/1ps
module tb_rstseq_ctrl;
    localparam int NG = 4;
    localparam int ST = 4;

    logic          clk = 1'b0;
    logic          por_n = 1'b1;
    logic          cold_req = 1'b0;
    logic          warm_req = 1'b0;
    logic          clku_boot_ack = 1'b0;
    logic          clku_clk_ready = 1'b0;
    logic          clku_rst_n;
    logic [NG-1:0] mod_rst_n;
    logic          clku_boot_req;
    logic          busy;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    rstseq_ctrl #(.NGRP(NG), .STEP(ST), .SYNC_STAGES(2)) dut (
        .clk            (clk),
        .por_n          (por_n),
        .cold_req       (cold_req),
        .warm_req       (warm_req),
        .clku_boot_ack  (clku_boot_ack),
        .clku_clk_ready (clku_clk_ready),
        .clku_rst_n     (clku_rst_n),
        .mod_rst_n      (mod_rst_n),
        .clku_boot_req  (clku_boot_req),
        .busy           (busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called right after the negedge at which ack/ready was driven.
    // Group k is first seen at negedge 4(k+1)+1; busy low at 4*NG+1.
    task automatic measure_release(input string req);
        int first[NG];
        int busy_low = -1;
        int early = 0;
        for (int k = 0; k < NG; k++) first[k] = -1;
        for (int n = 1; n <= ST*NG + 3; n++) begin
            @(negedge clk);
            for (int k = 0; k < NG; k++)
                if (mod_rst_n[k] && first[k] < 0) first[k] = n;
            if (!busy && busy_low < 0) busy_low = n;
            if (n < ST + 1 && mod_rst_n != '0) early = 1;
        end
        chk(req, "no group before first step", early, 0);
        for (int k = 0; k < NG; k++)
            chk({req, " R7"}, $sformatf("group %0d release cycle", k), first[k], ST*(k+1) + 1);
        chk({req, " R8"}, "busy fall cycle", busy_low, ST*NG + 1);
    endtask

    task automatic wait_boot_req(output int seen);
        seen = 0;
        for (int n = 0; n < 10 && !seen; n++) begin
            @(negedge clk);
            if (clku_boot_req) seen = 1;
        end
    endtask

    task automatic t_power_on;
        @(negedge clk);
        chk("R10", "clku_rst_n in por", int'(clku_rst_n), 0);
        chk("R10", "mod_rst_n in por", int'(mod_rst_n), 0);
        chk("R8", "busy in por", int'(busy), 1);
        chk("R6", "boot_req in por", int'(clku_boot_req), 0);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", "clku_rst_n after release", int'(clku_rst_n), 1);
        repeat (6) @(negedge clk);
        chk("R2", "modules held without ready", int'(mod_rst_n), 0);
        chk("R1", "modules held while clku just released", int'(busy), 1);
        clku_clk_ready = 1'b1;
        measure_release("R1");
        chk("R8", "all released at idle", int'(mod_rst_n), (1 << NG) - 1);
    endtask

    task automatic t_warm_basic;
        int seen;
        @(negedge clk);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        wait_boot_req(seen);
        chk("R4", "boot_req raised", seen, 1);
        chk("R4", "modules asserted", int'(mod_rst_n), 0);
        chk("R3", "clku kept running", int'(clku_rst_n), 1);
        repeat (8) @(negedge clk);
        chk("R5", "modules held awaiting ack", int'(mod_rst_n), 0);
        chk("R6", "boot_req held", int'(clku_boot_req), 1);
        clku_boot_ack = 1'b1;
        @(negedge clk);
        chk("R6", "boot_req dropped after ack", int'(clku_boot_req), 0);
        chk("R5", "no release right at ack", int'(mod_rst_n), 0);
        measure_release_offset("R5");
        chk("R3", "clku still running", int'(clku_rst_n), 1);
        clku_boot_ack = 1'b0;
    endtask

    // Same as measure_release, but one negedge has already been consumed.
    task automatic measure_release_offset(input string req);
        int first[NG];
        int busy_low = -1;
        for (int k = 0; k < NG; k++) first[k] = -1;
        for (int n = 2; n <= ST*NG + 3; n++) begin
            @(negedge clk);
            for (int k = 0; k < NG; k++)
                if (mod_rst_n[k] && first[k] < 0) first[k] = n;
            if (!busy && busy_low < 0) busy_low = n;
        end
        for (int k = 0; k < NG; k++)
            chk({req, " R7"}, $sformatf("warm group %0d release cycle", k), first[k], ST*(k+1) + 1);
        chk({req, " R8"}, "warm busy fall cycle", busy_low, ST*NG + 1);
    endtask

    task automatic t_stale_ack;
        int seen;
        clku_boot_ack = 1'b1;
        @(negedge clk);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        repeat (8) @(negedge clk);
        chk("R6", "no request while stale ack", int'(clku_boot_req), 0);
        chk("R4", "modules asserted while draining", int'(mod_rst_n), 0);
        chk("R8", "busy while draining", int'(busy), 1);
        clku_boot_ack = 1'b0;
        wait_boot_req(seen);
        chk("R6", "request after ack fell", seen, 1);
        clku_boot_ack = 1'b1;
        measure_release("R6");
        clku_boot_ack = 1'b0;
    endtask

    task automatic t_cold_in_warm;
        int seen;
        int bad = 0;
        int done = 0;
        @(negedge clk);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        wait_boot_req(seen);
        chk("R9", "in boot request", seen, 1);
        #1 cold_req = 1'b1;
        #1;
        chk("R10", "async clku reset", int'(clku_rst_n), 0);
        chk("R9", "request dropped on cold", int'(clku_boot_req), 0);
        chk("R9", "modules asserted on cold", int'(mod_rst_n), 0);
        repeat (3) @(negedge clk);
        cold_req = 1'b0;
        for (int n = 0; n < 40 && !done; n++) begin
            @(negedge clk);
            if (!clku_rst_n && mod_rst_n != '0) bad = 1;
            if (clku_boot_req) bad = 1;
            if (!busy) done = 1;
        end
        chk("R9", "cold path without request", bad, 0);
        chk("R9", "cold path completed", done, 1);
        chk("R1", "all released after cold path", int'(mod_rst_n), (1 << NG) - 1);
    endtask

    task automatic t_same_cycle;
        clku_clk_ready = 1'b0;
        @(negedge clk);
        warm_req = 1'b1;
        cold_req = 1'b1;
        #1;
        chk("R9", "cold wins same cycle clku", int'(clku_rst_n), 0);
        @(negedge clk);
        warm_req = 1'b0;
        cold_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "clku out after cold", int'(clku_rst_n), 1);
        chk("R9", "no warm request after cold", int'(clku_boot_req), 0);
        chk("R2", "modules wait for ready", int'(mod_rst_n), 0);
        clku_clk_ready = 1'b1;
        measure_release("R9");
    endtask

    task automatic t_warm_ignored;
        int seen = 0;
        @(negedge clk);
        clku_clk_ready = 1'b0;
        por_n = 1'b0;
        #1;
        chk("R10", "por asserts modules", int'(mod_rst_n), 0);
        @(negedge clk);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        clku_clk_ready = 1'b1;
        repeat (3) @(negedge clk);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (clku_boot_req) seen = 1;
        end
        chk("R11", "warm during release ignored", seen, 0);
        chk("R11", "busy low after sequence", int'(busy), 0);
        chk("R11", "modules released", int'(mod_rst_n), (1 << NG) - 1);
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2 por_n = 1'b0;
        repeat (3) @(negedge clk);
        t_power_on();
        t_warm_basic();
        t_stale_ack();
        t_cold_in_warm();
        t_same_cycle();
        t_warm_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule